// File: doc/BRIEF.md
# Byte-Stream Register Access Engine

This block sits between a host byte FIFO and an on-chip register bus with 8-bit data and 16-bit addresses. The host sends compact binary commands. Each command starts with one header byte, which may be followed by address and data bytes. The engine turns each data-access command into single-byte read or write strobes on the register bus. It returns read results on the outgoing byte stream.

A persistent 16-bit address pointer is shared across commands. A header may supply a new base address, or it may reuse the pointer. When the header asks for post-increment, the pointer advances past the transferred bytes after the command.

A small set of local commands reads and writes engine state without touching the bus: error status, the pointer bytes, an add-to-pointer operation, a fixed cookie, the command timeout and a parser reset. A command that stalls part-way for longer than the programmed number of milliseconds is abandoned and flagged in the status.

Top module: `bytecmd_engine`

## Requirements
- R1: After reset, `tx_valid`, `bus_wr` and `bus_rd` are low, `rx_ready` is high, the pointer is 0x0000, the status is 0x00 and the timeout value equals parameter `INIT_TIMEOUT_MS`.
- R2: A header with bits [7:6] = 01 is a data access. Bit 5 = 1 means write and 0 means read. Bit 3 = 1 enables post-increment. Bit 2 = 1 means two address bytes follow. Bits [1:0] select the length: 00 = 1, 01 = 2, 10 = 4, 11 = 8 bytes.
- R3: When bit 2 is set, the low address byte arrives first and the high byte second. The supplied address becomes the pointer at the end of the command.
- R4: An N-byte transfer accesses base, base+1, …, base+N-1. For a write, each accepted data byte drives `bus_wr` for one cycle, in the same cycle as the byte, with that address and the byte as `bus_wdata`. For a read, `bus_rd` is high for one cycle and the sampled `bus_rdata` is offered on `tx_data` from the next cycle.
- R5: With post-increment, the pointer ends at base + N (modulo 2^16). Without it, the pointer ends at base.
- R6: When bit 2 is clear, the current pointer is the base, and no address bytes are consumed.
- R7: Local reads 0xD8 and 0xD9 return the pointer's low and high byte. Local writes 0xF8 and 0xF9 replace the low and high byte. 0xFA adds the following byte, zero-extended, to the pointer.
- R8: Local read 0xDF returns 0x5A.
- R9: Local read 0xC1 returns the status: bit 6 = timeout, bit 5 = invalid write, bit 4 = overflow, bit 3 = watchdog, all other bits 0. Local write 0xE1 loads bits 6..3 from its data byte, so writing 0x00 clears all errors.
- R10: Local write 0xEB sets the timeout in milliseconds (0 disables it). Local read 0xCB returns it.
- R11: If the engine waits for further bytes of a started command for timeout × `CYCLES_PER_MS` cycles, it sets status bit 6, issues no bus access for the partial command, and treats the next byte as a header.
- R12: Headers with bits [7:6] = 10 or 00, 0xFF, and any local code not listed in R7 to R10 consume no further bytes, cause no bus access and no reply, and leave the pointer unchanged.
- R13: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Host byte available |
| rx_data | input | 8 | Host byte |
| rx_ready | output | 1 | Engine accepts a host byte this cycle |
| tx_valid | output | 1 | Reply byte available |
| tx_data | output | 8 | Reply byte |
| tx_ready | input | 1 | Host takes the reply byte this cycle |
| bus_addr | output | 16 | Register bus address |
| bus_wr | output | 1 | Register write strobe |
| bus_wdata | output | 8 | Register write data |
| bus_rd | output | 1 | Register read strobe |
| bus_rdata | input | 8 | Register read data, valid in the cycle of `bus_rd` |

## Verification
A wrong pointer or base register is invisible until the next access that uses it. The bench therefore reads the pointer back through the local commands after every kind of command, and follows pointer-relative transfers with checks of the exact bus addresses. A parser that loses its place shows up within one command as a byte at the wrong address or as an extra or missing reply byte. The scoreboard reports any unexpected strobe or reply byte. A broken timeout shows in the status byte read right after the stall, together with the absence of any write strobe during it.

// File: rtl/bytecmd_pkg.sv
package bytecmd_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 4;

    localparam logic [DATA_W-1:0] LC_RD_STAT = 8'hC1;
    localparam logic [DATA_W-1:0] LC_RD_TMO  = 8'hCB;
    localparam logic [DATA_W-1:0] LC_RD_PLO  = 8'hD8;
    localparam logic [DATA_W-1:0] LC_RD_PHI  = 8'hD9;
    localparam logic [DATA_W-1:0] LC_RD_COOK = 8'hDF;
    localparam logic [DATA_W-1:0] LC_WR_STAT = 8'hE1;
    localparam logic [DATA_W-1:0] LC_WR_TMO  = 8'hEB;
    localparam logic [DATA_W-1:0] LC_WR_PLO  = 8'hF8;
    localparam logic [DATA_W-1:0] LC_WR_PHI  = 8'hF9;
    localparam logic [DATA_W-1:0] LC_WR_PADD = 8'hFA;
    localparam logic [DATA_W-1:0] LC_RESET   = 8'hFF;

    localparam logic [DATA_W-1:0] COOKIE_VAL = 8'h5A;
    localparam logic [DATA_W-1:0] STAT_MASK  = 8'h78;
    localparam int                STAT_TMO   = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALO,
        ST_AHI,
        ST_WDAT,
        ST_RD,
        ST_SEND,
        ST_LWD
    } state_e;

    typedef enum logic [2:0] {
        K_IGNORE,
        K_DATA,
        K_LRD,
        K_LWR,
        K_RESET
    } kind_e;

    typedef struct packed {
        kind_e            kind;
        logic             wr;
        logic             ai;
        logic             has_addr;
        logic [CNT_W-1:0] len;
    } hdr_t;

    typedef struct packed {
        state_e            st;
        logic [ADDR_W-1:0] ptr;
        logic [ADDR_W-1:0] base;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  len;
        logic              wr;
        logic              ai;
        logic              loc;
        logic [DATA_W-1:0] lcode;
        logic [DATA_W-1:0] status;
        logic [DATA_W-1:0] tmo;
        logic [DATA_W-1:0] txd;
    } regs_t;

endpackage

// File: rtl/bytecmd_hdr_dec.sv
module bytecmd_hdr_dec
    import bytecmd_pkg::*;
(
    input  logic [DATA_W-1:0] hdr_byte,
    output hdr_t              hdr
);
    localparam int SZ_W = 2;

    logic [SZ_W-1:0] size_code;
    logic            is_lrd;
    logic            is_lwr;

    assign size_code = hdr_byte[SZ_W-1:0];

    always_comb begin
        is_lrd = (hdr_byte == LC_RD_STAT) || (hdr_byte == LC_RD_TMO) ||
                 (hdr_byte == LC_RD_PLO)  || (hdr_byte == LC_RD_PHI) ||
                 (hdr_byte == LC_RD_COOK);
        is_lwr = (hdr_byte == LC_WR_STAT) || (hdr_byte == LC_WR_TMO) ||
                 (hdr_byte == LC_WR_PLO)  || (hdr_byte == LC_WR_PHI) ||
                 (hdr_byte == LC_WR_PADD);
    end

    always_comb begin
        hdr          = '0;
        hdr.kind     = K_IGNORE;
        hdr.wr       = hdr_byte[5];
        hdr.ai       = hdr_byte[3];
        hdr.has_addr = hdr_byte[2];
        hdr.len      = CNT_W'(1) << size_code;
        if (hdr_byte[7:6] == 2'b01) begin
            hdr.kind = K_DATA;
        end else if (hdr_byte == LC_RESET) begin
            hdr.kind = K_RESET;
        end else if (is_lrd) begin
            hdr.kind = K_LRD;
        end else if (is_lwr) begin
            hdr.kind = K_LWR;
        end
    end
endmodule

// File: rtl/bytecmd_timer.sv
module bytecmd_timer #(
    parameter int CYCLES_PER_MS = 50000,
    parameter int MS_W          = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [MS_W-1:0] limit_ms,
    output logic            expire
);
    localparam int PRE_W = $clog2(CYCLES_PER_MS + 1);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYCLES_PER_MS - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [MS_W-1:0]  ms;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!run) begin
            tmr_d = '0;
        end else if (tmr_q.pre == PRE_LAST) begin
            tmr_d.pre = '0;
            tmr_d.ms  = tmr_q.ms + MS_W'(1);
        end else begin
            tmr_d.pre = tmr_q.pre + PRE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign expire = run && (limit_ms != '0) && (tmr_q.ms == limit_ms);
endmodule

// File: rtl/bytecmd_lrd_mux.sv
module bytecmd_lrd_mux
    import bytecmd_pkg::*;
(
    input  logic [DATA_W-1:0] code,
    input  logic [DATA_W-1:0] status,
    input  logic [DATA_W-1:0] tmo,
    input  logic [ADDR_W-1:0] ptr,
    output logic [DATA_W-1:0] value
);
    always_comb begin
        unique case (code)
            LC_RD_STAT: value = status & STAT_MASK;
            LC_RD_TMO:  value = tmo;
            LC_RD_PLO:  value = ptr[7:0];
            LC_RD_PHI:  value = ptr[15:8];
            LC_RD_COOK: value = COOKIE_VAL;
            default:    value = '0;
        endcase
    end
endmodule

// File: rtl/bytecmd_engine.sv
module bytecmd_engine
    import bytecmd_pkg::*;
#(
    parameter int CYCLES_PER_MS   = 50000,
    parameter int INIT_TIMEOUT_MS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    output logic [15:0]       bus_addr,
    output logic              bus_wr,
    output logic [7:0]        bus_wdata,
    output logic              bus_rd,
    input  logic [7:0]        bus_rdata
);
    localparam logic [DATA_W-1:0] TMO_RST = DATA_W'(INIT_TIMEOUT_MS);

    regs_t             q, d;
    hdr_t              hdr;
    logic [DATA_W-1:0] lrd_val;
    logic              tmo_run;
    logic              tmo_hit;
    logic [CNT_W-1:0]  cnt_nxt;
    logic              last_byte;
    logic [ADDR_W-1:0] end_ptr;

    bytecmd_hdr_dec u_dec (
        .hdr_byte (rx_data),
        .hdr      (hdr)
    );

    bytecmd_lrd_mux u_lrd (
        .code   (rx_data),
        .status (q.status),
        .tmo    (q.tmo),
        .ptr    (q.ptr),
        .value  (lrd_val)
    );

    // the timer only runs while a started command waits for host bytes
    assign tmo_run = (q.st == ST_ALO) || (q.st == ST_AHI) ||
                     (q.st == ST_WDAT) || (q.st == ST_LWD);

    bytecmd_timer #(
        .CYCLES_PER_MS (CYCLES_PER_MS),
        .MS_W          (DATA_W)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (tmo_run),
        .limit_ms (q.tmo),
        .expire   (tmo_hit)
    );

    assign cnt_nxt   = q.cnt + CNT_W'(1);
    assign last_byte = (cnt_nxt == q.len);
    assign end_ptr   = q.ai ? (q.base + ADDR_W'(q.len)) : q.base;

    always_comb begin
        d         = q;
        rx_ready  = 1'b0;
        tx_valid  = 1'b0;
        bus_wr    = 1'b0;
        bus_rd    = 1'b0;
        bus_addr  = q.base + ADDR_W'(q.cnt);
        bus_wdata = rx_data;

        if (tmo_hit) begin
            d.st               = ST_IDLE;
            d.status[STAT_TMO] = 1'b1;
        end else begin
            unique case (q.st)
                ST_IDLE: begin
                    rx_ready = 1'b1;
                    if (rx_valid) begin
                        unique case (hdr.kind)
                            K_DATA: begin
                                d.wr  = hdr.wr;
                                d.ai  = hdr.ai;
                                d.len = hdr.len;
                                d.cnt = '0;
                                d.loc = 1'b0;
                                if (hdr.has_addr) begin
                                    d.st = ST_ALO;
                                end else begin
                                    d.base = q.ptr;
                                    d.st   = hdr.wr ? ST_WDAT : ST_RD;
                                end
                            end
                            K_LRD: begin
                                d.txd = lrd_val;
                                d.loc = 1'b1;
                                d.st  = ST_SEND;
                            end
                            K_LWR: begin
                                d.lcode = rx_data;
                                d.st    = ST_LWD;
                            end
                            default: d.st = ST_IDLE;
                        endcase
                    end
                end
                ST_ALO: begin
                    rx_ready = 1'b1;
                    if (rx_valid) begin
                        d.base[7:0] = rx_data;
                        d.st        = ST_AHI;
                    end
                end
                ST_AHI: begin
                    rx_ready = 1'b1;
                    if (rx_valid) begin
                        d.base[15:8] = rx_data;
                        d.st         = q.wr ? ST_WDAT : ST_RD;
                    end
                end
                ST_WDAT: begin
                    rx_ready = 1'b1;
                    if (rx_valid) begin
                        bus_wr = 1'b1;
                        if (last_byte) begin
                            d.ptr = end_ptr;
                            d.st  = ST_IDLE;
                        end else begin
                            d.cnt = cnt_nxt;
                        end
                    end
                end
                ST_RD: begin
                    bus_rd = 1'b1;
                    d.txd  = bus_rdata;
                    d.st   = ST_SEND;
                end
                ST_SEND: begin
                    tx_valid = 1'b1;
                    if (tx_ready) begin
                        if (q.loc) begin
                            d.st = ST_IDLE;
                        end else if (last_byte) begin
                            d.ptr = end_ptr;
                            d.st  = ST_IDLE;
                        end else begin
                            d.cnt = cnt_nxt;
                            d.st  = ST_RD;
                        end
                    end
                end
                ST_LWD: begin
                    rx_ready = 1'b1;
                    if (rx_valid) begin
                        unique case (q.lcode)
                            LC_WR_STAT: d.status    = rx_data & STAT_MASK;
                            LC_WR_TMO:  d.tmo       = rx_data;
                            LC_WR_PLO:  d.ptr[7:0]  = rx_data;
                            LC_WR_PHI:  d.ptr[15:8] = rx_data;
                            LC_WR_PADD: d.ptr       = q.ptr + ADDR_W'(rx_data);
                            default:    d.ptr       = q.ptr;
                        endcase
                        d.st = ST_IDLE;
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= ST_IDLE;
            q.tmo <= TMO_RST;
        end else begin
            q <= d;
        end
    end

    assign tx_data = q.txd;
endmodule

// File: rtl/bytecmd_engine_chk.sv
module bytecmd_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic       rx_ready,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_data,
    input logic       bus_wr,
    input logic       bus_rd
);
    // R4: a write strobe only accompanies an accepted host byte
    a_r4_wr_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> (rx_valid && rx_ready));

    // R4: a read strobe is followed by the reply byte in the next cycle
    a_r4_rd_then_tx: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> tx_valid);

    // R4: no host byte is taken while a read is in flight
    a_r4_rd_blocks_rx: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> !rx_ready);

    // R2: a command is either a read or a write, never both at once
    a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));

    // R13: reply byte holds under back-pressure
    a_r13_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
endmodule

bind bytecmd_engine bytecmd_engine_chk u_chk (.*);

// File: tb/sim_bytecmd_engine.sv
module sim_bytecmd_engine;
    localparam int CPM  = 4;
    localparam int TMO0 = 3;

    typedef struct {
        logic [7:0] v;
        string      tag;
    } tx_item_t;

    typedef struct {
        logic [15:0] a;
        logic [7:0]  v;
        string       tag;
    } wr_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_ready;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b1;
    logic [15:0] bus_addr;
    logic        bus_wr;
    logic [7:0]  bus_wdata;
    logic        bus_rd;
    logic [7:0]  bus_rdata;

    logic [7:0]  mem [256];
    logic [7:0]  exp_mem [256];
    tx_item_t    txq[$];
    wr_item_t    wrq[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          ended = 0;

    always #2 clk = ~clk;

    bytecmd_engine #(.CYCLES_PER_MS(CPM), .INIT_TIMEOUT_MS(TMO0)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
    );

    // register bus slave
    assign bus_rdata = mem[bus_addr[7:0]];
    always @(posedge clk) if (bus_wr) mem[bus_addr[7:0]] <= bus_wdata;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
        #1;
        while (!rx_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic exp_tx(input logic [7:0] v, input string tag);
        tx_item_t it;
        it.v = v; it.tag = tag;
        txq.push_back(it);
    endtask

    task automatic exp_wr(input logic [15:0] a, input logic [7:0] v, input string tag);
        wr_item_t it;
        it.a = a; it.v = v; it.tag = tag;
        wrq.push_back(it);
        exp_mem[a[7:0]] = v;
    endtask

    task automatic lread(input logic [7:0] code, input logic [7:0] v, input string tag);
        exp_tx(v, tag);
        send(code);
    endtask

    task automatic lwrite(input logic [7:0] code, input logic [7:0] v);
        send(code);
        send(v);
    endtask

    task automatic drain();
        for (int i = 0; i < 100 && (txq.size() != 0 || tx_valid); i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // scoreboard monitor, samples 1 ns after the falling edge
    always begin
        @(negedge clk);
        #1;
        if (rst_n && !ended) begin
            if (tx_valid && tx_ready) begin
                if (txq.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL R12: unexpected reply actual %h expected none", tx_data);
                end else begin
                    tx_item_t it;
                    it = txq.pop_front();
                    check(it.tag, {8'h00, tx_data}, {8'h00, it.v});
                end
            end
            if (bus_wr) begin
                if (wrq.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL R11: unexpected write actual %h expected none", bus_addr);
                end else begin
                    wr_item_t it;
                    it = wrq.pop_front();
                    check({it.tag, " addr"}, bus_addr, it.a);
                    check({it.tag, " data"}, {8'h00, bus_wdata}, {8'h00, it.v});
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        ended = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]     = 8'(i) ^ 8'hA5;
            exp_mem[i] = 8'(i) ^ 8'hA5;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state at the ports
        check("R1 tx_valid", {15'd0, tx_valid}, 16'd0);
        check("R1 rx_ready", {15'd0, rx_ready}, 16'd1);
        check("R1 strobes", {14'd0, bus_wr, bus_rd}, 16'd0);
        lread(8'hD8, 8'h00, "R1 ptr lo");
        lread(8'hD9, 8'h00, "R1 ptr hi");
        lread(8'hC1, 8'h00, "R1 status");
        lread(8'hCB, 8'(TMO0), "R1 timeout");
        lread(8'hDF, 8'h5A, "R8 cookie");

        // R2 R3 R4 R5: write 4 bytes at 0x0010 with post-increment
        exp_wr(16'h0010, 8'hAA, "R4 w0");
        exp_wr(16'h0011, 8'hBB, "R4 w1");
        exp_wr(16'h0012, 8'hCC, "R4 w2");
        exp_wr(16'h0013, 8'hDD, "R4 w3");
        send(8'h6E); send(8'h10); send(8'h00);
        send(8'hAA); send(8'hBB); send(8'hCC); send(8'hDD);
        lread(8'hD8, 8'h14, "R5 ptr after ai");

        // R6: write 2 bytes at the pointer, no increment
        exp_wr(16'h0014, 8'hEE, "R6 w0");
        exp_wr(16'h0015, 8'hFF, "R6 w1");
        send(8'h61); send(8'hEE); send(8'hFF);
        lread(8'hD8, 8'h14, "R5 ptr kept");

        // R4: 8-byte read at 0x0010, address becomes pointer (R3)
        for (int i = 0; i < 8; i++) exp_tx(exp_mem[16 + i], "R4 rd8");
        send(8'h47); send(8'h10); send(8'h00);
        lread(8'hD8, 8'h10, "R3 ptr lo");
        lread(8'hD9, 8'h00, "R3 ptr hi");

        // R4: 4-byte read at 0x21
        for (int i = 0; i < 4; i++) exp_tx(exp_mem[8'h21 + i], "R4 rd4");
        send(8'h46); send(8'h21); send(8'h00);

        // R5: 2-byte read at 0x00FE with increment crosses into 0x0100
        exp_tx(exp_mem[8'hFE], "R4 rdFE");
        exp_tx(exp_mem[8'hFF], "R4 rdFF");
        send(8'h4D); send(8'hFE); send(8'h00);
        lread(8'hD8, 8'h00, "R5 ptr lo carry");
        lread(8'hD9, 8'h01, "R5 ptr hi carry");

        // R7: pointer writes and add
        lwrite(8'hF8, 8'h30);
        lwrite(8'hF9, 8'h12);
        lwrite(8'hFA, 8'hF0);
        lread(8'hD8, 8'h20, "R7 ptr lo");
        lread(8'hD9, 8'h13, "R7 ptr hi");

        // R6 R5: 1-byte read at the pointer with increment
        exp_tx(exp_mem[8'h20], "R6 rd ptr");
        send(8'h48);
        lread(8'hD8, 8'h21, "R5 ptr inc1");

        // R9: status write and clear
        lwrite(8'hE1, 8'hFF);
        lread(8'hC1, 8'h78, "R9 status set");
        lwrite(8'hE1, 8'h00);
        lread(8'hC1, 8'h00, "R9 status clear");

        // R10: timeout value
        lwrite(8'hEB, 8'h05);
        lread(8'hCB, 8'h05, "R10 timeout rd");

        // R11: stall after the low address byte of a write
        send(8'h64); send(8'h33);
        repeat (40) @(negedge clk);
        lread(8'hC1, 8'h40, "R11 timeout flag");
        lwrite(8'hE1, 8'h00);
        lread(8'hD8, 8'h21, "R11 ptr kept");

        // R12: ignored headers consume nothing else
        send(8'h80); send(8'h9F); send(8'hC5); send(8'h00);
        send(8'hFF); send(8'hE5);
        lread(8'hD8, 8'h21, "R12 ptr lo");
        lread(8'hD9, 8'h13, "R12 ptr hi");

        // R13: back-pressure on the reply
        drain();
        @(negedge clk);
        tx_ready = 1'b0;
        exp_tx(8'h5A, "R13 released");
        send(8'hDF);
        repeat (4) @(negedge clk);
        #1;
        check("R13 held valid", {15'd0, tx_valid}, 16'd1);
        check("R13 held data", {8'h00, tx_data}, 16'h005A);
        @(negedge clk);
        tx_ready = 1'b1;

        drain();
        check("R12 no pending replies", 16'(txq.size()), 16'd0);
        check("R4 no pending writes", 16'(wrq.size()), 16'd0);
        ended = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule